// File: doc/BRIEF.md
# Polled Mailbox Command Sequencer

This block is the host-side engine that issues one command at a time to a device command mailbox and waits for the device to finish it. A requester first loads its input payload words into a small internal buffer. It then presents an opcode, an input length in bytes and a copy-back flag on a valid/ready handshake. The engine drives a 64-bit register master port with one access at a time. It checks that the device is ready and that the length fits. It then writes the payload and the command word, rings the doorbell, and polls the doorbell until the device clears it or a cycle budget runs out. At the end it reports the outcome on a one-cycle done pulse.

The sequence is a state machine. Its states are IDLE, DEV (read device status), CAP (read capability), BELL_CHK (read control), WR_PAY (write payload words), WR_CMD (write command), RING (set doorbell), POLL (read control repeatedly), POLL_LAST (the one extra read after the budget expires), RD_STAT (read return code), RD_LEN (read output length), RD_PAY (read output words) and DONE. Each transition happens when the device acknowledges the current access.

The transitions are:
- IDLE to DEV on an accepted request.
- DEV to CAP when the device is ready, otherwise DEV to DONE.
- CAP to BELL_CHK when the length fits, otherwise CAP to DONE.
- BELL_CHK to WR_PAY, or to WR_CMD for an empty payload, or to DONE when the doorbell is busy.
- WR_PAY to WR_CMD after the last word.
- WR_CMD to RING, then RING to POLL.
- POLL to RD_STAT on a clear doorbell, or to POLL_LAST once the budget is spent.
- POLL_LAST to RD_STAT on a clear doorbell, otherwise to DONE.
- RD_STAT to RD_LEN.
- RD_LEN to RD_PAY when a copy-back is asked for and there are output words, otherwise to DONE.
- RD_PAY to DONE after the last word.
- DONE to IDLE.

A timed-out command is simply dropped; the device is not reset.

Top module: `mbx_cmd_engine`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, done is 0 and reg_req is 0.
- R2: Only one command runs at a time. From the cycle after a request is accepted until the command's done pulse, req_ready is 0. A request held during that time is not taken and yields no second done.
- R3: The first access is a read of the device status register at DEV_BASE. Unless its bit 4 is 1 and its bits 3:2 equal 1, the command ends with result 3 (not ready) and no register write.
- R4: The capability register (mailbox offset 0x00) gives c in bits 4:0. An input length above 2^c bytes, or above 8*BUF_WORDS bytes, ends the command with result 2 (too long) and no register write.
- R5: If bit 0 of the control register (offset 0x04) reads 1 before any write, the command ends with result 3 and no register write.
- R6: For an accepted length L, ceil(L/8) full 64-bit words are written in order. Buffer word i goes to offset 0x20+8*i.
- R7: After the payload, the command register (offset 0x08) is written with the opcode in bits 15:0 and L in bits 36:16. Then offset 0x04 is written with 1 (doorbell). These are the last two writes of the command.
- R8: Offset 0x04 is read until bit 0 reads 0. Then offset 0x10 is read once, its bits 47:32 appear on done_rc, and done_result is 0 (success).
- R9: The polling budget is TIMEOUT_CYC cycles from the doorbell write's acknowledge. Budget expiry is checked only at the end of a poll read, and expiry means that read ended at least TIMEOUT_CYC cycles after the doorbell acknowledge. After expiry exactly one more read of 0x04 is made. If it shows 0 the command finishes as in R8. Otherwise done_result is 1 (timeout), done_rc is 0 and no further access is made.
- R10: After completion, bits 36:16 of offset 0x08 appear on done_out_len. If req_copy_out was set, ceil(len/8) words are read from 0x20+8*i and each is shown on out_data with out_valid high and out_idx = i. With the flag clear, no output word is read.
- R11: done is high for exactly one cycle per command. A register access holds reg_req, reg_we, reg_addr and reg_wdata steady until reg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_opcode | input | 16 | Command opcode |
| req_len | input | 21 | Input payload length in bytes |
| req_copy_out | input | 1 | Read the output payload back after completion |
| buf_we | input | 1 | Input payload buffer write enable |
| buf_idx | input | BUF_IDX_W | Input payload buffer word index |
| buf_wdata | input | 64 | Input payload buffer word |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | ADDR_W | Register byte address |
| reg_wdata | output | 64 | Write data |
| reg_ack | input | 1 | Access complete (read data valid) |
| reg_rdata | input | 64 | Read data |
| out_valid | output | 1 | Output payload word valid |
| out_idx | output | 19 | Output payload word index |
| out_data | output | 64 | Output payload word |
| done | output | 1 | One-cycle completion pulse |
| done_result | output | 2 | 0 ok, 1 timeout, 2 too long, 3 not ready |
| done_rc | output | 16 | Device return code |
| done_out_len | output | 21 | Output payload length in bytes |

## Verification
The bench builds the engine with a four-word buffer and a 20-cycle polling budget, and models the device as a register file that answers every access two cycles after it starts. With this budget the clear-on-read-K point of the device model can be swept from K = 1 up past the expiry boundary. The sweep covers a doorbell that clears on the final re-sample and one that never clears. The small buffer lets every input length from 0 to 32 bytes run. Each length uses a different output length and copy choice, and the capability and buffer limits are each probed at their edges.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OPC_W = 16;
    localparam int LEN_W = 21;
    localparam int IDX_W = LEN_W - 2;

    localparam int OFF_CAP  = 'h00;
    localparam int OFF_CTRL = 'h04;
    localparam int OFF_CMD  = 'h08;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_PAY  = 'h20;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_CAP, ST_BELL_CHK, ST_WR_PAY, ST_WR_CMD, ST_RING,
        ST_POLL, ST_POLL_LAST, ST_RD_STAT, ST_RD_LEN, ST_RD_PAY, ST_DONE
    } mbx_state_e;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_TIMEOUT   = 2'd1,
        RES_TOO_LONG  = 2'd2,
        RES_NOT_READY = 2'd3
    } mbx_result_e;

    // Number of 64-bit words covering n bytes.
    function automatic logic [IDX_W-1:0] words_of(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] t;
        t = {1'b0, n} + (LEN_W+1)'(7);
        return t[LEN_W:3];
    endfunction

endpackage

// File: rtl/mbx_payload_buf.sv
module mbx_payload_buf #(
    parameter int WORDS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [63:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [63:0]      rdata
);
    logic [63:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Value seen at an edge is the number of cycles spent in the run window minus one.
    assign expired = (cnt_q >= LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (!expired)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mbx_len_gate.sv
module mbx_len_gate #(
    parameter int BUF_WORDS = 4,
    parameter int LEN_W     = 21
) (
    input  logic [LEN_W-1:0] len,
    input  logic [4:0]       cap_log2,
    output logic             fits
);
    localparam logic [32:0] BUF_BYTES = 33'(BUF_WORDS * 8);

    logic [32:0] cap_bytes;
    logic [32:0] len_w;

    assign cap_bytes = 33'd1 << cap_log2;
    assign len_w     = 33'(len);
    assign fits      = (len_w <= cap_bytes) && (len_w <= BUF_BYTES);
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int ADDR_W               = 12,
    parameter logic [ADDR_W-1:0] MBX_BASE = '0,
    parameter logic [ADDR_W-1:0] DEV_BASE = ADDR_W'('h800),
    parameter int BUF_WORDS            = 4,
    parameter int TIMEOUT_CYC          = 1000,
    localparam int BUF_IDX_W           = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [OPC_W-1:0]     req_opcode,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_copy_out,
    input  logic                 buf_we,
    input  logic [BUF_IDX_W-1:0] buf_idx,
    input  logic [63:0]          buf_wdata,
    output logic                 reg_req,
    output logic                 reg_we,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [63:0]          reg_wdata,
    input  logic                 reg_ack,
    input  logic [63:0]          reg_rdata,
    output logic                 out_valid,
    output logic [IDX_W-1:0]     out_idx,
    output logic [63:0]          out_data,
    output logic                 done,
    output logic [1:0]           done_result,
    output logic [15:0]          done_rc,
    output logic [LEN_W-1:0]     done_out_len
);

    mbx_state_e       st_q, st_nxt;
    mbx_result_e      res_q;
    logic [OPC_W-1:0] opc_q;
    logic [LEN_W-1:0] len_q, outlen_q;
    logic             copy_q;
    logic [IDX_W-1:0] idx_q, nwords_q;
    logic [15:0]      rc_q;

    logic        len_fits, expired, dev_ok, bell_busy, last_word;
    logic [IDX_W-1:0] out_words;
    logic [63:0] buf_rdata;

    mbx_payload_buf #(.WORDS(BUF_WORDS), .IDX_W(BUF_IDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_idx),
        .wdata (buf_wdata),
        .ridx  (idx_q[BUF_IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    mbx_len_gate #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_gate (
        .len      (len_q),
        .cap_log2 (reg_rdata[4:0]),
        .fits     (len_fits)
    );

    mbx_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_POLL),
        .expired (expired)
    );

    assign dev_ok    = reg_rdata[4] && (reg_rdata[3:2] == 2'b01);
    assign bell_busy = reg_rdata[0];
    assign last_word = (idx_q == nwords_q - 1'b1);
    assign out_words = words_of(reg_rdata[36:16]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:      if (req_valid) st_nxt = ST_DEV;
            ST_DEV:       if (reg_ack) st_nxt = dev_ok ? ST_CAP : ST_DONE;
            ST_CAP:       if (reg_ack) st_nxt = len_fits ? ST_BELL_CHK : ST_DONE;
            ST_BELL_CHK:  if (reg_ack) st_nxt = bell_busy ? ST_DONE :
                                                 ((nwords_q == '0) ? ST_WR_CMD : ST_WR_PAY);
            ST_WR_PAY:    if (reg_ack && last_word) st_nxt = ST_WR_CMD;
            ST_WR_CMD:    if (reg_ack) st_nxt = ST_RING;
            ST_RING:      if (reg_ack) st_nxt = ST_POLL;
            ST_POLL:      if (reg_ack) begin
                              if (!bell_busy)   st_nxt = ST_RD_STAT;
                              else if (expired) st_nxt = ST_POLL_LAST;
                          end
            ST_POLL_LAST: if (reg_ack) st_nxt = bell_busy ? ST_DONE : ST_RD_STAT;
            ST_RD_STAT:   if (reg_ack) st_nxt = ST_RD_LEN;
            ST_RD_LEN:    if (reg_ack) st_nxt = (copy_q && out_words != '0) ? ST_RD_PAY : ST_DONE;
            ST_RD_PAY:    if (reg_ack && last_word) st_nxt = ST_DONE;
            ST_DONE:      st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // Command context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= RES_OK;
            opc_q    <= '0;
            len_q    <= '0;
            outlen_q <= '0;
            copy_q   <= 1'b0;
            idx_q    <= '0;
            nwords_q <= '0;
            rc_q     <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    opc_q    <= req_opcode;
                    len_q    <= req_len;
                    copy_q   <= req_copy_out;
                    nwords_q <= words_of(req_len);
                    idx_q    <= '0;
                    rc_q     <= '0;
                    outlen_q <= '0;
                    res_q    <= RES_OK;
                end
                ST_DEV:       if (reg_ack && !dev_ok)   res_q <= RES_NOT_READY;
                ST_CAP:       if (reg_ack && !len_fits) res_q <= RES_TOO_LONG;
                ST_BELL_CHK:  if (reg_ack && bell_busy) res_q <= RES_NOT_READY;
                ST_WR_PAY:    if (reg_ack) idx_q <= idx_q + 1'b1;
                ST_POLL_LAST: if (reg_ack && bell_busy) res_q <= RES_TIMEOUT;
                ST_RD_STAT:   if (reg_ack) rc_q <= reg_rdata[47:32];
                ST_RD_LEN:    if (reg_ack) begin
                    outlen_q <= reg_rdata[36:16];
                    nwords_q <= out_words;
                    idx_q    <= '0;
                end
                ST_RD_PAY:    if (reg_ack) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_req   = 1'b1;
        reg_we    = 1'b0;
        reg_addr  = MBX_BASE + ADDR_W'(OFF_CTRL);
        reg_wdata = '0;
        unique case (st_q)
            ST_IDLE, ST_DONE: reg_req = 1'b0;
            ST_DEV:      reg_addr = DEV_BASE;
            ST_CAP:      reg_addr = MBX_BASE + ADDR_W'(OFF_CAP);
            ST_WR_PAY: begin
                reg_we    = 1'b1;
                reg_addr  = MBX_BASE + ADDR_W'(OFF_PAY) + ADDR_W'({idx_q, 3'b000});
                reg_wdata = buf_rdata;
            end
            ST_WR_CMD: begin
                reg_we    = 1'b1;
                reg_addr  = MBX_BASE + ADDR_W'(OFF_CMD);
                reg_wdata = {27'd0, len_q, opc_q};
            end
            ST_RING: begin
                reg_we    = 1'b1;
                reg_wdata = 64'd1;
            end
            ST_RD_STAT:  reg_addr = MBX_BASE + ADDR_W'(OFF_STAT);
            ST_RD_LEN:   reg_addr = MBX_BASE + ADDR_W'(OFF_CMD);
            ST_RD_PAY:   reg_addr = MBX_BASE + ADDR_W'(OFF_PAY) + ADDR_W'({idx_q, 3'b000});
            default: ;
        endcase
    end

    assign req_ready    = (st_q == ST_IDLE);
    assign out_valid    = (st_q == ST_RD_PAY) && reg_ack;
    assign out_idx      = idx_q;
    assign out_data     = reg_rdata;
    assign done         = (st_q == ST_DONE);
    assign done_result  = res_q;
    assign done_rc      = rc_q;
    assign done_out_len = outlen_q;

endmodule

// File: rtl/mbx_cmd_engine_chk.sv
module mbx_cmd_engine_chk #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] MBX_BASE = '0,
    parameter int TIMEOUT_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [63:0]       reg_wdata,
    input logic              reg_ack,
    input logic              done,
    input logic [1:0]        done_result
);
    localparam logic [ADDR_W-1:0] CTRL_A = MBX_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] CMD_A  = MBX_BASE + ADDR_W'(8);

    logic              wrote_q, rung_q;
    logic [ADDR_W-1:0] last_wr_q;
    logic [31:0]       since_ring_q;
    logic              wr_ack, ring_ack;

    assign wr_ack   = reg_req && reg_ack && reg_we;
    assign ring_ack = wr_ack && (reg_addr == CTRL_A) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q      <= 1'b0;
            rung_q       <= 1'b0;
            last_wr_q    <= '0;
            since_ring_q <= '0;
        end else begin
            if (req_valid && req_ready) begin
                wrote_q <= 1'b0;
                rung_q  <= 1'b0;
            end else if (wr_ack) begin
                wrote_q <= 1'b1;
            end
            if (wr_ack) last_wr_q <= reg_addr;
            if (ring_ack) begin
                rung_q       <= 1'b1;
                since_ring_q <= '0;
            end else if (rung_q && since_ring_q != '1) begin
                since_ring_q <= since_ring_q + 1'b1;
            end
        end
    end

    // R2
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));

    // R4
    no_write_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_result[1]) |-> !wrote_q);

    // R7
    ring_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ack |-> (last_wr_q == CMD_A));

    // R9
    timeout_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_result == 2'd1) |-> (rung_q && since_ring_q >= 32'(TIMEOUT_CYC)));

endmodule

bind mbx_cmd_engine mbx_cmd_engine_chk #(
    .ADDR_W(ADDR_W), .MBX_BASE(MBX_BASE), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .done(done), .done_result(done_result)
);

// File: tb/mbx_cmd_engine_bench.sv
module mbx_cmd_engine_bench;
    localparam int TMO   = 20;
    localparam int NREAD = (TMO + 1) / 2 + 1;   // poll reads incl. final re-sample, 2-cycle device

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_copy_out = 0, buf_we = 0;
    logic [15:0] req_opcode = 0;
    logic [20:0] req_len = 0;
    logic [1:0]  buf_idx = 0;
    logic [63:0] buf_wdata = 0;
    logic        req_ready, reg_req, reg_we, out_valid, done;
    logic [11:0] reg_addr;
    logic [63:0] reg_wdata, out_data;
    logic [18:0] out_idx;
    logic [1:0]  done_result;
    logic [15:0] done_rc;
    logic [20:0] done_out_len;
    logic        reg_ack;
    logic [63:0] reg_rdata;

    mbx_cmd_engine #(.TIMEOUT_CYC(TMO)) u_mbx_cmd_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_len(req_len), .req_copy_out(req_copy_out),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .out_valid(out_valid), .out_idx(out_idx),
        .out_data(out_data), .done(done), .done_result(done_result), .done_rc(done_rc),
        .done_out_len(done_out_len)
    );

    // Device configuration, driven only by the stimulus
    logic        cfg_load = 0, cfg_bell = 0;
    logic [63:0] cfg_dev = 64'h14, cfg_cap = 64'd5;
    int          cfg_clear_k = 1;
    logic [20:0] cfg_outlen = 0;
    logic [15:0] cfg_rc = 0;

    // Device model state, driven only by the model
    logic        bell, rung;
    int          polls, wr_cnt, stat_rd, done_cnt, out_cnt;
    logic [63:0] cmd_reg;
    logic [63:0] pmem [64];
    logic [11:0] wlog_a [32];
    logic [63:0] wlog_d [32];
    logic [63:0] obs [64];

    int checks = 0, errors = 0, cyc = 0;

    function automatic logic [63:0] in_pat(int i, int len);
        return {16'hBEEF, 16'(len), 32'(i + 100)};
    endfunction
    function automatic logic [63:0] out_pat(int i, logic [15:0] rc);
        return {rc, 16'h5A00, 32'(i * 7 + 1)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            reg_ack <= 0; reg_rdata <= 0; bell <= 0; rung <= 0; polls <= 0;
            wr_cnt <= 0; stat_rd <= 0; cmd_reg <= 0;
        end else if (cfg_load) begin
            reg_ack <= 0; bell <= cfg_bell; rung <= 0; polls <= 0;
            wr_cnt <= 0; stat_rd <= 0;
        end else if (reg_req && !reg_ack) begin
            reg_ack <= 1;
            if (reg_we) begin
                if (wr_cnt < 32) begin
                    wlog_a[wr_cnt] <= reg_addr;
                    wlog_d[wr_cnt] <= reg_wdata;
                end
                wr_cnt <= wr_cnt + 1;
                if (reg_addr == 12'h004 && reg_wdata[0]) begin
                    bell <= 1; rung <= 1; polls <= 0;
                end else if (reg_addr == 12'h008) cmd_reg <= reg_wdata;
                else if (reg_addr >= 12'h020 && reg_addr < 12'h800)
                    pmem[(reg_addr - 12'h020) >> 3] <= reg_wdata;
            end else begin
                if (reg_addr == 12'h800) reg_rdata <= cfg_dev;
                else if (reg_addr == 12'h000) reg_rdata <= cfg_cap;
                else if (reg_addr == 12'h004) begin
                    if (rung && bell) begin
                        polls <= polls + 1;
                        if (polls + 1 == cfg_clear_k) begin
                            bell <= 0;
                            reg_rdata <= 64'd0;
                            cmd_reg[36:16] <= cfg_outlen;
                            for (int i = 0; i < 64; i++) pmem[i] <= out_pat(i, cfg_rc);
                        end else reg_rdata <= 64'd1;
                    end else reg_rdata <= {63'd0, bell};
                end
                else if (reg_addr == 12'h008) reg_rdata <= cmd_reg;
                else if (reg_addr == 12'h010) begin
                    stat_rd <= stat_rd + 1;
                    reg_rdata <= {16'd0, cfg_rc, 32'd0};
                end
                else reg_rdata <= pmem[(reg_addr - 12'h020) >> 3];
            end
        end else reg_ack <= 0;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            done_cnt <= 0; out_cnt <= 0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (out_valid) begin
                obs[out_idx[5:0]] <= out_data;
                out_cnt <= out_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic setup(input logic [63:0] dev, input logic [63:0] cap, input logic bl,
                         input int k, input int olen, input int rc);
        @(negedge clk);
        cfg_dev = dev; cfg_cap = cap; cfg_bell = bl; cfg_clear_k = k;
        cfg_outlen = 21'(olen); cfg_rc = 16'(rc); cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    logic [1:0]  d_res;
    logic [15:0] d_rc;
    logic [20:0] d_len;
    int          busy_hits, out_base;

    task automatic run_cmd(input logic [15:0] opc, input int len, input bit copy, input bit hold);
        int n = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            buf_we = 1; buf_idx = 2'(i); buf_wdata = in_pat(i, len);
        end
        @(negedge clk);
        buf_we = 0;
        out_base = out_cnt;
        req_valid = 1; req_opcode = opc; req_len = 21'(len); req_copy_out = copy;
        @(negedge clk);
        busy_hits = 0;
        if (hold) req_opcode = 16'h7777;
        else req_valid = 0;
        while (!done && n < 2000) begin
            if (req_ready) busy_hits++;
            @(negedge clk);
            n++;
        end
        chk(n < 2000, "R11 done reached", n, 0);
        d_res = done_result; d_rc = done_rc; d_len = done_out_len;
        req_valid = 0;
        @(negedge clk);
    endtask

    function automatic int words(int b);
        return (b + 7) / 8;
    endfunction

    task automatic check_ok(input logic [15:0] opc, input int len, input bit copy, input int olen, input int rc);
        int nw = words(len);
        int ow = copy ? words(olen) : 0;
        chk(d_res == 2'd0, "R8 result ok", d_res, 0);
        chk(d_rc == 16'(rc), "R8 return code", d_rc, rc);
        chk(stat_rd == 1, "R8 one status read", stat_rd, 1);
        chk(d_len == 21'(olen), "R10 out length", d_len, olen);
        chk(wr_cnt == nw + 2, "R6 write count", wr_cnt, nw + 2);
        for (int j = 0; j < nw; j++) begin
            chk(wlog_a[j] == 12'(32 + 8 * j), "R6 payload addr", wlog_a[j], 32 + 8 * j);
            chk(wlog_d[j] == in_pat(j, len), "R6 payload data", wlog_d[j], in_pat(j, len));
        end
        chk(wlog_a[nw] == 12'h008, "R7 cmd addr", wlog_a[nw], 8);
        chk(wlog_d[nw] == {27'd0, 21'(len), opc}, "R7 cmd value", wlog_d[nw], {27'd0, 21'(len), opc});
        chk(wlog_a[nw + 1] == 12'h004 && wlog_d[nw + 1] == 64'd1, "R7 doorbell write",
            wlog_d[nw + 1], 1);
        chk(out_cnt - out_base == ow, "R10 out word count", out_cnt - out_base, ow);
        for (int j = 0; j < ow; j++)
            chk(obs[j] == out_pat(j, 16'(rc)), "R10 out data", obs[j], out_pat(j, 16'(rc)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
        chk(done == 0 && reg_req == 0, "R1 quiet in reset", {done, reg_req}, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && done == 0 && reg_req == 0, "R1 idle after reset",
            {req_ready, done, reg_req}, 3'b100);

        // Length sweep: R6, R7, R8, R10
        for (int len = 0; len <= 32; len++) begin
            setup(64'h14, 64'd5, 0, 1 + len % 4, 40 - len, len * 37 + 1);
            run_cmd(16'(16'h4000 + len), len, len[0], 0);
            check_ok(16'(16'h4000 + len), len, len[0], 40 - len, len * 37 + 1);
        end

        // R2: request held during a command
        setup(64'h14, 64'd5, 0, 3, 8, 5);
        run_cmd(16'h1234, 8, 1, 1);
        chk(busy_hits == 0, "R2 not ready while busy", busy_hits, 0);
        repeat (6) @(negedge clk);
        chk(done_cnt == 34, "R2 no second command", done_cnt, 34);
        chk(wlog_d[1][15:0] == 16'h1234, "R2 first opcode kept", wlog_d[1][15:0], 16'h1234);
        check_ok(16'h1234, 8, 1, 8, 5);

        // R4: length limits
        setup(64'h14, 64'd4, 0, 1, 0, 0);
        run_cmd(16'h10, 17, 0, 0);
        chk(d_res == 2'd2, "R4 over capability", d_res, 2);
        chk(wr_cnt == 0, "R4 no write", wr_cnt, 0);
        setup(64'h14, 64'd4, 0, 1, 0, 9);
        run_cmd(16'h11, 16, 0, 0);
        check_ok(16'h11, 16, 0, 0, 9);
        setup(64'h14, 64'd6, 0, 1, 0, 0);
        run_cmd(16'h12, 33, 0, 0);
        chk(d_res == 2'd2, "R4 over buffer", d_res, 2);
        chk(wr_cnt == 0, "R4 no write buffer", wr_cnt, 0);

        // R3: device readiness variants (bit4 ready, bits3:2 media)
        for (int v = 0; v < 4; v++) begin
            logic [63:0] dv;
            dv = (v == 0) ? 64'h04 : 64'(32'h10 | (((v == 1) ? 0 : v) << 2));
            setup(dv, 64'd5, 0, 1, 0, 0);
            run_cmd(16'h20, 8, 0, 0);
            chk(d_res == 2'd3, "R3 device not ready", d_res, 3);
            chk(wr_cnt == 0, "R3 no write", wr_cnt, 0);
        end

        // R5: doorbell already busy
        setup(64'h14, 64'd5, 1, 1, 0, 0);
        run_cmd(16'h30, 8, 0, 0);
        chk(d_res == 2'd3, "R5 doorbell busy", d_res, 3);
        chk(wr_cnt == 0, "R5 no write", wr_cnt, 0);

        // R9: clear point sweep around the budget
        for (int k = 1; k <= NREAD + 3; k++) begin
            setup(64'h14, 64'd5, 0, k, 16, 7);
            run_cmd(16'h40, 8, 0, 0);
            if (k <= NREAD) begin
                chk(d_res == 2'd0, "R9 cleared within budget", d_res, 0);
                chk(polls == k, "R9 poll reads", polls, k);
                chk(d_len == 21'd16, "R10 out length", d_len, 16);
            end else begin
                chk(d_res == 2'd1, "R9 timeout", d_res, 1);
                chk(polls == NREAD, "R9 single re-sample", polls, NREAD);
                chk(stat_rd == 0 && d_rc == 0, "R9 dropped", {stat_rd, d_rc}, 0);
            end
        end
        setup(64'h14, 64'd5, 0, 0, 0, 0);
        run_cmd(16'h41, 0, 1, 0);
        chk(d_res == 2'd1, "R9 never clears", d_res, 1);
        chk(polls == NREAD, "R9 never clears reads", polls, NREAD);

        finish_run();
    end
endmodule